// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a single-request internal bus to an external asynchronous static RAM of 128K bytes. Each request is accepted on a valid/ready handshake. The block then runs one complete memory cycle on the active-low chip, write and output enable lines. A read returns its byte with a one-cycle response pulse. A write produces no response.

The memory has no clock, so the controller derives its wait counts at elaboration time from the system clock period. The memory needs 10 ns for a full access or write cycle and 5 ns from output enable to valid data. The controller holds every pin steady for enough whole clock cycles to cover both figures.

The bidirectional data lines are split into a driven value, a drive enable and a sampled input. The controller turns on its drivers only while output enable is high, so the memory's outputs are already off when it drives. Between accesses the memory is left in standby with chip enable high.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset, and whenever no access is in progress, chip enable, write enable and output enable are all high (inactive), the data drive enable is low and `req_ready` is high.
- R2: `req_ready` is high only when the controller is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Exactly one access runs per accepted request, and `req_ready` is low on every cycle while chip enable is low.
- R3: A read holds chip enable low, output enable low and write enable high for W cycles, where W = max(ceil(T_CYC_NS/CLK_NS), ceil(T_OE_NS/CLK_NS), 1). The address stays at the request address throughout, and the data lines are sampled on the last of these cycles.
- R4: Exactly W cycles after a read request is accepted, `rsp_valid` is high for one cycle and `rsp_rdata` carries the sampled byte. `req_ready` returns on the next cycle, W+1 cycles after acceptance.
- R5: A write runs in three steps, all with chip enable low and output enable high. First comes one setup cycle with write enable high and drivers off. Then write enable is low for W cycles with the data driven. Then comes one hold cycle with write enable high and the data still driven. `req_ready` returns W+2 cycles after acceptance.
- R6: The data drive enable is never high while output enable is low. Driver and memory never both drive the data lines.
- R7: The address and write data are captured at acceptance. The address stays stable for as long as chip enable is low, and changes on the request inputs after acceptance have no effect on the running access.
- R8: A write never raises `rsp_valid`. A byte written to an address is returned by later reads of that address until it is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid |
| mem_addr | output | 17 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data lines |
| mem_dq_oe | output | 1 | Drive enable for the data lines |
| mem_dq_in | input | 8 | Value sampled from the data lines |

## Verification
The bench memory model presents the complement of the stored byte until enough nanoseconds have passed since the read began. A controller that samples one cycle early therefore returns inverted data. The model also measures the width of each write-enable low pulse and whether data is still driven at the rising edge, so a short pulse or an early driver release is reported as a timing failure. Read-after-write and write-after-read pairs are run back to back, so a missing turnaround shows up as the drive enable overlapping output enable. The request inputs are scrambled just after acceptance, which exposes a controller that forwards them instead of latching them.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD    = 3'd1,
      ST_RDONE = 3'd2,
      ST_WSET  = 3'd3,
      ST_WPUL  = 3'd4,
      ST_WHOLD = 3'd5
   } asram_st_e;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic dq_oe;
      logic rsp;
   } asram_ctl_t;

   localparam asram_ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, rsp: 1'b0};

   // whole cycles covering t_ns at period p_ns, never fewer than one
   function automatic int cycles_for(input int t_ns, input int p_ns);
      int r;
      r = (t_ns + p_ns - 1) / p_ns;
      return (r < 1) ? 1 : r;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic asram_ctl_t ctl_of(input asram_st_e s);
      asram_ctl_t c;
      c = CTL_IDLE;
      case (s)
         ST_RD:    begin c.ce_n = 1'b0; c.oe_n = 1'b0; end
         ST_RDONE: begin c.rsp = 1'b1; end
         ST_WSET:  begin c.ce_n = 1'b0; end
         ST_WPUL:  begin c.ce_n = 1'b0; c.we_n = 1'b0; c.dq_oe = 1'b1; end
         ST_WHOLD: begin c.ce_n = 1'b0; c.dq_oe = 1'b1; end
         default:  c = CTL_IDLE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/asram_wait_timer.sv
`timescale 1ns/1ps
module asram_wait_timer #(
   parameter int WAIT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic last
);
   localparam int CNT_W = (WAIT > 1) ? $clog2(WAIT) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
`timescale 1ns/1ps
module asram_fsm
   import asram_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      req_write,
   input  logic      tmr_last,
   output asram_st_e state_q,
   output asram_st_e state_d,
   output logic      ready,
   output logic      accept,
   output logic      tmr_load,
   output logic      capture
);
   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (req_valid) state_d = req_write ? ST_WSET : ST_RD;
         ST_RD:    if (tmr_last) state_d = ST_RDONE;
         ST_RDONE: state_d = ST_IDLE;
         ST_WSET:  state_d = ST_WPUL;
         ST_WPUL:  if (tmr_last) state_d = ST_WHOLD;
         ST_WHOLD: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign ready    = (state_q == ST_IDLE);
   assign accept   = ready && req_valid;
   assign tmr_load = ((state_d == ST_RD)   && (state_q != ST_RD)) ||
                     ((state_d == ST_WPUL) && (state_q != ST_WPUL));
   assign capture  = (state_q == ST_RD) && tmr_last;
endmodule

// File: rtl/asram_ctl_out.sv
`timescale 1ns/1ps
module asram_ctl_out
   import asram_pkg::*;
#(
   parameter bit REG_CTRL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  asram_st_e  state_in,
   output asram_ctl_t ctl
);
   generate
      if (REG_CTRL) begin : g_reg
         // state_in is the next state: registering its decode gives glitch-free pins
         asram_ctl_t ctl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctl_q <= CTL_IDLE;
            else        ctl_q <= ctl_of(state_in);
         end
         assign ctl = ctl_q;
      end else begin : g_comb
         // state_in is the current state: decode only
         assign ctl = ctl_of(state_in);
      end
   endgenerate
endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
module asram_datapath #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         dq_out <= '0;
      end else if (accept) begin
         addr   <= req_addr;
         dq_out <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= '0;
      else if (capture) rdata <= dq_in;
   end
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 8,
   parameter int CLK_NS   = 10,
   parameter int T_CYC_NS = 10,
   parameter int T_OE_NS  = 5,
   parameter bit REG_CTRL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int CYC_WAIT = cycles_for(T_CYC_NS, CLK_NS);
   localparam int OE_WAIT  = cycles_for(T_OE_NS, CLK_NS);
   localparam int ACC_WAIT = imax(CYC_WAIT, OE_WAIT);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_ctrl: address and data widths must be at least 1");
      end
      if (CLK_NS < 1 || T_CYC_NS < 1 || T_OE_NS < 1) begin : g_bad_time
         $error("asram_ctrl: clock period and memory timings must be positive");
      end
   endgenerate

   asram_st_e  state_q, state_d, st_for_ctl;
   asram_ctl_t ctl;
   logic       accept, tmr_load, tmr_last, capture;

   asram_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .tmr_last  (tmr_last),
      .state_q   (state_q),
      .state_d   (state_d),
      .ready     (req_ready),
      .accept    (accept),
      .tmr_load  (tmr_load),
      .capture   (capture)
   );

   asram_wait_timer #(.WAIT(ACC_WAIT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .last  (tmr_last)
   );

   generate
      if (REG_CTRL) begin : g_st_next
         assign st_for_ctl = state_d;
      end else begin : g_st_cur
         assign st_for_ctl = state_q;
      end
   endgenerate

   asram_ctl_out #(.REG_CTRL(REG_CTRL)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_in (st_for_ctl),
      .ctl      (ctl)
   );

   asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dq_in     (mem_dq_in),
      .addr      (mem_addr),
      .dq_out    (mem_dq_out),
      .rdata     (rsp_rdata)
   );

   assign mem_ce_n  = ctl.ce_n;
   assign mem_we_n  = ctl.we_n;
   assign mem_oe_n  = ctl.oe_n;
   assign mem_dq_oe = ctl.dq_oe;
   assign rsp_valid = ctl.rsp;
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk
   import asram_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 8,
   parameter int CLK_NS   = 10,
   parameter int T_CYC_NS = 10,
   parameter int T_OE_NS  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);
   localparam int W = imax(cycles_for(T_CYC_NS, CLK_NS), cycles_for(T_OE_NS, CLK_NS));

   int we_lo_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         we_lo_cnt <= 0;
      else if (!mem_we_n) we_lo_cnt <= we_lo_cnt + 1;
      else                we_lo_cnt <= 0;
   end

   p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready);

   p_read_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n));

   p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt == W));

   p_data_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

   p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   p_write_no_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !rsp_valid);
endmodule

bind asram_ctrl asram_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS),
   .T_CYC_NS(T_CYC_NS), .T_OE_NS(T_OE_NS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
   .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;
   localparam int TB_CLK_NS = 4;
   localparam int T_CYC = 10;
   localparam int T_OE  = 5;
   localparam int NC = ((T_CYC + TB_CLK_NS - 1) / TB_CLK_NS) < 1 ? 1 : (T_CYC + TB_CLK_NS - 1) / TB_CLK_NS;
   localparam int NO = ((T_OE + TB_CLK_NS - 1) / TB_CLK_NS) < 1 ? 1 : (T_OE + TB_CLK_NS - 1) / TB_CLK_NS;
   localparam int W  = (NC > NO) ? NC : NO;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [16:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(TB_CLK_NS / 2.0) clk = ~clk;

   asram_ctrl #(.CLK_NS(TB_CLK_NS), .T_CYC_NS(T_CYC), .T_OE_NS(T_OE)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural memory with timing checks ----------------
   logic [7:0] model_mem [logic [16:0]];
   logic [7:0] shadow    [logic [16:0]];

   function automatic logic [7:0] dflt(input logic [16:0] a);
      return a[7:0] ^ a[16:9] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] model_val(input logic [16:0] a);
      return model_mem.exists(a) ? model_mem[a] : dflt(a);
   endfunction

   function automatic logic [7:0] exp_val(input logic [16:0] a);
      return shadow.exists(a) ? shadow[a] : dflt(a);
   endfunction

   int rd_cnt = 0;
   logic [7:0] dq_q = 8'h00;
   assign mem_dq_in = dq_q;

   // read path: data becomes valid only once both access times have elapsed
   always @(posedge clk) begin
      logic rd_on;
      logic [7:0] v;
      rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
      v = model_val(mem_addr);
      if (rd_on && (rd_cnt + 2) * TB_CLK_NS >= T_CYC && (rd_cnt + 2) * TB_CLK_NS >= T_OE)
         dq_q <= v;
      else
         dq_q <= ~v;
      rd_cnt <= rd_on ? rd_cnt + 1 : 0;
   end

   // write path and contention: checked between edges
   logic we_prev = 1'b1;
   int   we_lo = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n)
            chk(1'b0, "R6", "memory and controller drive together", 1, 0);
         if (!we_prev && mem_we_n && !mem_ce_n) begin
            chk(we_lo * TB_CLK_NS >= T_CYC, "R5", "write-enable pulse ns", we_lo * TB_CLK_NS, T_CYC);
            chk(mem_dq_oe == 1'b1, "R5", "data driven at write-enable rise", mem_dq_oe, 1);
            model_mem[mem_addr] = mem_dq_out;
         end
      end
      we_lo   = (!mem_we_n) ? we_lo + 1 : 0;
      we_prev = mem_we_n;
   end

   // ---------------- stimulus ----------------
   function automatic logic [4:0] pins();
      return {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready};
   endfunction

   task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      // scramble request inputs after acceptance
      req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
   endtask

   task automatic do_write(input logic [16:0] a, input logic [7:0] d);
      issue(1'b1, a, d);
      // k = 0: setup
      chk(pins() == 5'b01100, "R5", "write setup pins", pins(), 5'b01100);
      chk(mem_addr == a, "R7", "write address latched", mem_addr, a);
      for (int k = 1; k <= W; k++) begin
         @(negedge clk);
         chk(pins() == 5'b00110, "R5", "write pulse pins", pins(), 5'b00110);
         chk(mem_dq_out == d && rsp_valid == 1'b0, "R8", "write data / no response",
             {rsp_valid, mem_dq_out}, {1'b0, d});
      end
      @(negedge clk);
      chk(pins() == 5'b01110 && mem_dq_out == d, "R5", "write hold pins",
          {pins(), mem_dq_out}, {5'b01110, d});
      @(negedge clk);
      chk(pins() == 5'b11101, "R1", "idle after write", pins(), 5'b11101);
      shadow[a] = d;
   endtask

   task automatic do_read(input logic [16:0] a);
      logic [7:0] e;
      e = exp_val(a);
      issue(1'b0, a, 8'h00);
      for (int k = 0; k < W; k++) begin
         if (k > 0) @(negedge clk);
         chk(pins() == 5'b01000 && mem_addr == a, "R3", "read pins and address",
             {pins(), mem_addr}, {5'b01000, a});
         chk(rsp_valid == 1'b0, "R2", "busy, no early response", rsp_valid, 0);
      end
      @(negedge clk);
      chk(rsp_valid == 1'b1 && req_ready == 1'b0, "R4", "response strobe at W",
          {rsp_valid, req_ready}, 2'b10);
      chk(rsp_rdata == e, "R8", "read data", rsp_rdata, e);
      @(negedge clk);
      chk(rsp_valid == 1'b0 && pins() == 5'b11101, "R4", "strobe one cycle, ready back",
          {rsp_valid, pins()}, {1'b0, 5'b11101});
   endtask

   function automatic logic [7:0] pat(input logic [16:0] a, input int salt);
      return 8'(a * 37 + (a >> 9) + salt);
   endfunction

   initial begin
      // reset state
      repeat (3) @(negedge clk);
      chk(pins() == 5'b11101 && rsp_valid == 1'b0, "R1", "pins in reset",
          {pins(), rsp_valid}, {5'b11101, 1'b0});
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(pins() == 5'b11101, "R1", "idle after reset", pins(), 5'b11101);
      chk(W == 3, "R3", "derived wait count", W, 3);

      // unwritten location reads memory contents
      do_read(17'h0ABCD);
      // walking-one addresses plus both ends
      do_write(17'h00000, pat(17'h00000, 1));
      do_write(17'h1FFFF, pat(17'h1FFFF, 1));
      for (int b = 0; b < 17; b++) do_write(17'(1) << b, pat(17'(1) << b, 1));
      do_read(17'h00000);
      do_read(17'h1FFFF);
      for (int b = 0; b < 17; b++) do_read(17'(1) << b);
      // write then read same address back to back, read then write
      for (int i = 0; i < 16; i++) begin
         logic [16:0] a;
         a = 17'(i * 8191 + 5);
         do_write(a, pat(a, i));
         do_read(a);
         do_write(a, ~pat(a, i));
         do_read(a);
      end
      // overwrite check on an earlier location
      do_write(17'h00004, 8'hC3);
      do_read(17'h00004);
      do_read(17'h00008);
      repeat (3) @(negedge clk);
      chk(pins() == 5'b11101, "R1", "final idle", pins(), 5'b11101);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule